// File: doc/BRIEF.md
# CRT Display Memory Address Generator

This block produces the frame buffer address for a character/graphics CRT controller. It is advanced by a character-clock enable. A memory address counter reloads from a line base register at the start of every active line. It then steps at one of three programmable character-clock intervals. Its 16-bit value is rearranged for byte, word or doubleword planar addressing. After that, address bits 13 and 14 can each be replaced by the two low bits of the row-scan counter. This lets a display split into interleaved banks. The result is registered and goes to the frame buffer decoder.

The same block holds the row-scan counter. That counter runs from 0 up to a programmable maximum scan line and then wraps. Each wrap advances the line base register by a programmable offset. The block also produces the clock enable for the vertical timing counter. This enable pulses on every horizontal retrace, or on every second one to double the effective vertical resolution. All controls are static inputs. The timing strobes (frame start, line start, horizontal retrace) are plain qualifiers sampled with the character-clock enable. Nothing is streamed, so there is no handshake and no back-pressure at any edge of the block.

Top module: `crtc_addr_gen`

## Requirements
- R1: All internal state (row-scan counter, line base, retrace phase, interval divider, memory address counter) changes only on clock cycles where `chr_en` is 1. `frame_start`, `line_start` and `hretrace` have no effect in other cycles.
- R2: `frame_start` with `chr_en` clears the row-scan counter to 0, loads the line base register with `start_addr`, and clears the retrace phase. This takes precedence over `hretrace`.
- R3: `hretrace` with `chr_en` (without `frame_start`) increments the row-scan counter. When the counter equals `max_scan`, it wraps to 0 instead.
- R4: `line_start` with `chr_en` loads the memory address counter from the line base register, or directly from `start_addr` if `frame_start` is also 1. It also clears the interval divider. Each row-scan wrap adds `line_offset` (modulo 2^16) to the line base register.
- R5: Outside a load, the address counter increments once every N enabled cycles after the load. The value of N depends on `{step4,step2}`: 00 gives N=1, 01 gives N=2, 10 gives N=4, and 11 gives N=2.
- R6: `addr_mode` 00 passes the counter value through unchanged (byte mode). Mode 01 rotates it left by one; bit 0 takes bit 15 when `word_src_hi`=1, otherwise bit 13 (word mode). Modes 10 and 11 shift it left by two, with bits 15:14 entering bits 1:0 (doubleword mode).
- R7: When `sub13_off`=0, bit 13 of the rearranged address is replaced by row-scan bit 0. When `sub13_off`=1, bit 13 passes unchanged.
- R8: When `sub14_off`=0, bit 14 of the rearranged address is replaced by row-scan bit 1. When `sub14_off`=1, bit 14 passes unchanged.
- R9: `vt_clk_en` is a one-cycle pulse in the cycle after an enabled `hretrace` that comes without `frame_start`. With `vt_half`=0, every such retrace produces a pulse. With `vt_half`=1, only every second retrace after frame start produces one, starting with the second.
- R10: `fb_addr` reflects the counter and row-scan values of the previous clock cycle (one register). Reset (`rst_n`=0) drives `fb_addr`, `row_scan` and `vt_clk_en` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_en | input | 1 | Character-clock enable |
| frame_start | input | 1 | Start of frame strobe |
| line_start | input | 1 | Start of active line strobe |
| hretrace | input | 1 | Horizontal retrace strobe |
| start_addr | input | 16 | Frame start address |
| line_offset | input | 16 | Line base increment per character row |
| max_scan | input | 5 | Last row-scan value before wrap |
| addr_mode | input | 2 | 00 byte, 01 word, 1x doubleword |
| word_src_hi | input | 1 | Word mode bit 0 source: 1 bit 15, 0 bit 13 |
| step2 | input | 1 | Interval control, see R5 |
| step4 | input | 1 | Interval control, see R5 |
| sub13_off | input | 1 | 0 replaces address bit 13 with row-scan bit 0 |
| sub14_off | input | 1 | 0 replaces address bit 14 with row-scan bit 1 |
| vt_half | input | 1 | Vertical enable on every second retrace |
| fb_addr | output | 16 | Registered frame buffer address |
| row_scan | output | 5 | Row-scan counter |
| vt_clk_en | output | 1 | Vertical timing counter clock enable |

## Verification
A wrong address counter or interval divider shows on `fb_addr` one clock after the step that went wrong. A wrong divider phase usually shows only at the first increment after a line load. For that reason the comparison runs on every clock, including cycles where the enable is low and the strobes are held high. A faulty row-scan counter shows at once on `row_scan`. In the next cycle it also shows on `fb_addr` bits 13 and 14, whenever substitution is on. A line base error shows only at the next line load, so each configuration runs more than one character row and at least one wrap. A retrace phase fault shows on `vt_clk_en` at the first or second retrace after frame start.

// File: rtl/crtc_addr_pkg.sv
package crtc_addr_pkg;

  // Planar address rearrangement selected by addr_mode
  typedef enum logic [1:0] {
    MAP_BYTE      = 2'b00,
    MAP_WORD      = 2'b01,
    MAP_DWORD     = 2'b10,
    MAP_DWORD_ALT = 2'b11
  } map_mode_e;

  localparam int unsigned MAX_STEP = 4;

  // Character clocks per address step for the {step4,step2} pair
  function automatic logic [2:0] step_interval(input logic s2, input logic s4);
    logic [2:0] n;
    case ({s4, s2})
      2'b00:   n = 3'd1;
      2'b01:   n = 3'd2;
      2'b10:   n = 3'd4;
      default: n = 3'd2;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/crtc_row_scan.sv
module crtc_row_scan #(
  parameter int unsigned AW  = 16,
  parameter int unsigned RSW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           chr_en,
  input  logic           frame_start,
  input  logic           hretrace,
  input  logic [AW-1:0]  start_addr,
  input  logic [AW-1:0]  line_offset,
  input  logic [RSW-1:0] max_scan,
  input  logic           vt_half,
  output logic [RSW-1:0] row_scan,
  output logic [AW-1:0]  line_base,
  output logic           vt_clk_en
);

  logic           retrace_ev;
  logic           last_row;
  logic           phase_q;

  assign retrace_ev = chr_en && hretrace && !frame_start;
  assign last_row   = (row_scan >= max_scan);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_scan  <= '0;
      line_base <= '0;
      phase_q   <= 1'b0;
      vt_clk_en <= 1'b0;
    end else begin
      vt_clk_en <= retrace_ev && (!vt_half || phase_q);
      if (chr_en) begin
        if (frame_start) begin
          row_scan  <= '0;
          line_base <= start_addr;
          phase_q   <= 1'b0;
        end else if (hretrace) begin
          phase_q <= ~phase_q;
          if (last_row) begin
            row_scan  <= '0;
            line_base <= line_base + line_offset;
          end else begin
            row_scan <= row_scan + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/crtc_ma_counter.sv
module crtc_ma_counter
  import crtc_addr_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chr_en,
  input  logic          frame_start,
  input  logic          line_start,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] line_base,
  input  logic          step2,
  input  logic          step4,
  output logic [AW-1:0] ma
);

  localparam int unsigned DIVW = $clog2(MAX_STEP);

  logic [2:0]      interval;
  logic [DIVW-1:0] limit;
  logic [DIVW-1:0] div_q;

  assign interval = step_interval(step2, step4);
  assign limit    = DIVW'(interval - 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma    <= '0;
      div_q <= '0;
    end else if (chr_en) begin
      if (line_start) begin
        ma    <= frame_start ? start_addr : line_base;
        div_q <= '0;
      end else if (div_q == limit) begin
        ma    <= ma + 1'b1;
        div_q <= '0;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/crtc_addr_map.sv
module crtc_addr_map
  import crtc_addr_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned RSW        = 5,
  parameter int unsigned SUB_LO_BIT = 13,
  parameter int unsigned SUB_HI_BIT = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  ma,
  input  logic [RSW-1:0] row_scan,
  input  logic [1:0]     addr_mode,
  input  logic           word_src_hi,
  input  logic           sub_lo_off,
  input  logic           sub_hi_off,
  output logic [AW-1:0]  fb_addr
);

  localparam int unsigned WORD_ALT_BIT = AW - 3;

  map_mode_e     mode;
  logic [AW-1:0] reorg;
  logic [AW-1:0] mapped;

  assign mode = map_mode_e'(addr_mode);

  always_comb begin
    case (mode)
      MAP_BYTE: reorg = ma;
      MAP_WORD: reorg = {ma[AW-2:0], word_src_hi ? ma[AW-1] : ma[WORD_ALT_BIT]};
      default:  reorg = {ma[AW-3:0], ma[AW-1:AW-2]};
    endcase
  end

  for (genvar i = 0; i < AW; i++) begin : g_bit
    if (i == SUB_LO_BIT) begin : g_lo
      assign mapped[i] = sub_lo_off ? reorg[i] : row_scan[0];
    end else if (i == SUB_HI_BIT) begin : g_hi
      assign mapped[i] = sub_hi_off ? reorg[i] : row_scan[1];
    end else begin : g_pass
      assign mapped[i] = reorg[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_addr <= '0;
    else        fb_addr <= mapped;
  end

endmodule

// File: rtl/crtc_addr_gen.sv
module crtc_addr_gen #(
  parameter int unsigned AW  = 16,
  parameter int unsigned RSW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           chr_en,
  input  logic           frame_start,
  input  logic           line_start,
  input  logic           hretrace,
  input  logic [AW-1:0]  start_addr,
  input  logic [AW-1:0]  line_offset,
  input  logic [RSW-1:0] max_scan,
  input  logic [1:0]     addr_mode,
  input  logic           word_src_hi,
  input  logic           step2,
  input  logic           step4,
  input  logic           sub13_off,
  input  logic           sub14_off,
  input  logic           vt_half,
  output logic [AW-1:0]  fb_addr,
  output logic [RSW-1:0] row_scan,
  output logic           vt_clk_en
);

  logic [AW-1:0] line_base;
  logic [AW-1:0] ma_val;

  crtc_row_scan #(.AW(AW), .RSW(RSW)) u_rs (
    .clk         (clk),
    .rst_n       (rst_n),
    .chr_en      (chr_en),
    .frame_start (frame_start),
    .hretrace    (hretrace),
    .start_addr  (start_addr),
    .line_offset (line_offset),
    .max_scan    (max_scan),
    .vt_half     (vt_half),
    .row_scan    (row_scan),
    .line_base   (line_base),
    .vt_clk_en   (vt_clk_en)
  );

  crtc_ma_counter #(.AW(AW)) u_ma (
    .clk         (clk),
    .rst_n       (rst_n),
    .chr_en      (chr_en),
    .frame_start (frame_start),
    .line_start  (line_start),
    .start_addr  (start_addr),
    .line_base   (line_base),
    .step2       (step2),
    .step4       (step4),
    .ma          (ma_val)
  );

  crtc_addr_map #(.AW(AW), .RSW(RSW), .SUB_LO_BIT(13), .SUB_HI_BIT(14)) u_map (
    .clk         (clk),
    .rst_n       (rst_n),
    .ma          (ma_val),
    .row_scan    (row_scan),
    .addr_mode   (addr_mode),
    .word_src_hi (word_src_hi),
    .sub_lo_off  (sub13_off),
    .sub_hi_off  (sub14_off),
    .fb_addr     (fb_addr)
  );

endmodule

// File: rtl/crtc_addr_gen_chk.sv
module crtc_addr_gen_chk #(
  parameter int unsigned AW  = 16,
  parameter int unsigned RSW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           chr_en,
  input logic           frame_start,
  input logic           line_start,
  input logic           hretrace,
  input logic [AW-1:0]  start_addr,
  input logic [RSW-1:0] max_scan,
  input logic           sub13_off,
  input logic           sub14_off,
  input logic [AW-1:0]  fb_addr,
  input logic [RSW-1:0] row_scan,
  input logic           vt_clk_en,
  input logic [AW-1:0]  ma_val,
  input logic [AW-1:0]  line_base
);

  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chr_en |=> ($stable(ma_val) && $stable(row_scan) && $stable(line_base)));

  // R3
  scan_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_scan <= max_scan);

  // R4
  line_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_en && line_start) |=> ma_val == $past(frame_start ? start_addr : line_base));

  // R7
  sub_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sub13_off |=> fb_addr[13] == $past(row_scan[0]));

  // R8
  sub_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sub14_off |=> fb_addr[14] == $past(row_scan[1]));

  // R9
  vt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vt_clk_en |-> $past(chr_en && hretrace && !frame_start));

endmodule

bind crtc_addr_gen crtc_addr_gen_chk #(.AW(AW), .RSW(RSW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chr_en      (chr_en),
  .frame_start (frame_start),
  .line_start  (line_start),
  .hretrace    (hretrace),
  .start_addr  (start_addr),
  .max_scan    (max_scan),
  .sub13_off   (sub13_off),
  .sub14_off   (sub14_off),
  .fb_addr     (fb_addr),
  .row_scan    (row_scan),
  .vt_clk_en   (vt_clk_en),
  .ma_val      (ma_val),
  .line_base   (line_base)
);

// File: tb/tb_crtc_addr_gen.sv
module tb_crtc_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chr_en = 1'b0, frame_start = 1'b0, line_start = 1'b0, hretrace = 1'b0;
  logic [15:0] start_addr = '0, line_offset = '0;
  logic [4:0]  max_scan = 5'd3;
  logic [1:0]  addr_mode = '0;
  logic        word_src_hi = 1'b0, step2 = 1'b0, step4 = 1'b0;
  logic        sub13_off = 1'b1, sub14_off = 1'b1, vt_half = 1'b0;
  logic [15:0] fb_addr;
  logic [4:0]  row_scan;
  logic        vt_clk_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit gap_mode = 1'b0;

  always #5 clk = ~clk;

  crtc_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .chr_en(chr_en), .frame_start(frame_start),
    .line_start(line_start), .hretrace(hretrace), .start_addr(start_addr),
    .line_offset(line_offset), .max_scan(max_scan), .addr_mode(addr_mode),
    .word_src_hi(word_src_hi), .step2(step2), .step4(step4),
    .sub13_off(sub13_off), .sub14_off(sub14_off), .vt_half(vt_half),
    .fb_addr(fb_addr), .row_scan(row_scan), .vt_clk_en(vt_clk_en)
  );

  // Behavioural reference model
  int m_rs, m_base, m_ma, m_cnt, m_phase, m_fb, m_vt;

  function automatic int ref_map(int a, int rs);
    int r;
    if (addr_mode == 2'b00)      r = a;
    else if (addr_mode == 2'b01) r = ((a * 2) % 65536) + (word_src_hi ? (a / 32768) : ((a / 8192) % 2));
    else                         r = ((a * 4) % 65536) + (a / 16384);
    if (!sub13_off) r = (r & ~(1 << 13)) | ((rs % 2) << 13);
    if (!sub14_off) r = (r & ~(1 << 14)) | (((rs / 2) % 2) << 14);
    return r;
  endfunction

  function automatic int ref_step();
    if (step2 && step4) return 2;
    if (step4)          return 4;
    if (step2)          return 2;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rs = 0; m_base = 0; m_ma = 0; m_cnt = 0; m_phase = 0; m_fb = 0; m_vt = 0;
    end else begin
      int old_base;
      m_fb = ref_map(m_ma, m_rs);
      m_vt = (chr_en && hretrace && !frame_start && (!vt_half || m_phase == 1)) ? 1 : 0;
      old_base = m_base;
      if (chr_en) begin
        if (frame_start) begin
          m_rs = 0; m_base = start_addr; m_phase = 0;
        end else if (hretrace) begin
          m_phase = 1 - m_phase;
          if (m_rs >= max_scan) begin
            m_rs = 0; m_base = (m_base + line_offset) % 65536;
          end else m_rs = m_rs + 1;
        end
        if (line_start) begin
          m_ma = frame_start ? int'(start_addr) : old_base;
          m_cnt = 0;
        end else begin
          m_cnt = m_cnt + 1;
          if (m_cnt >= ref_step()) begin
            m_cnt = 0; m_ma = (m_ma + 1) % 65536;
          end
        end
      end
    end
  end

  // Every-clock comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (int'(fb_addr) != m_fb) begin
        fails++;
        $display("FAIL R1 R4 R5 R6 R7 R8 R10 fb_addr got %h exp %h at %0t", fb_addr, m_fb[15:0], $time);
      end
      checks++;
      if (int'(row_scan) != m_rs) begin
        fails++;
        $display("FAIL R1 R2 R3 row_scan got %0d exp %0d at %0t", row_scan, m_rs, $time);
      end
      checks++;
      if (int'(vt_clk_en) != m_vt) begin
        fails++;
        $display("FAIL R9 vt_clk_en got %0d exp %0d at %0t", vt_clk_en, m_vt, $time);
      end
    end
  end

  // One enabled character clock, optionally followed by an idle cycle with all strobes high
  task automatic step(input logic fs, input logic ls, input logic hr);
    chr_en = 1'b1; frame_start = fs; line_start = ls; hretrace = hr;
    @(negedge clk);
    if (gap_mode) begin
      chr_en = 1'b0; frame_start = 1'b1; line_start = 1'b1; hretrace = 1'b1;
      @(negedge clk);
    end
    chr_en = 1'b0; frame_start = 1'b0; line_start = 1'b0; hretrace = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (fb_addr !== 16'h0 || row_scan !== 5'd0 || vt_clk_en !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset state got %h/%0d/%0d exp 0000/0/0", fb_addr, row_scan, vt_clk_en);
    end
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_frame(input bit joint_start);
    if (joint_start) step(1'b1, 1'b1, 1'b0);
    else step(1'b1, 1'b0, 1'b0);
    for (int ln = 0; ln < 10; ln++) begin
      if (!(joint_start && ln == 0)) step(1'b0, 1'b1, 1'b0);
      for (int c = 0; c < 16; c++) step(1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b1);
      for (int c = 0; c < 3; c++) step(1'b0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    @(negedge clk);
    for (int k = 0; k < 48; k++) begin
      addr_mode   = 2'(k % 3);
      if (k % 9 == 8) addr_mode = 2'b11;
      step2       = ((k / 3) % 4) % 2 == 1;
      step4       = ((k / 3) % 4) / 2 == 1;
      sub13_off   = ((k / 12) % 4) % 2 == 1;
      sub14_off   = ((k / 12) % 4) / 2 == 1;
      vt_half     = (k / 2) % 2 == 1;
      word_src_hi = (k / 5) % 2 == 1;
      gap_mode    = (k % 4 == 1);
      max_scan    = (k % 5 == 4) ? 5'd0 : 5'd3;
      start_addr  = 16'((k * 16'h1357 + 16'hA000) % 65536);
      line_offset = 16'(40 + k * 997);
      do_reset();
      run_frame(k % 6 == 0);
      run_frame(1'b0);
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired got running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule